// File: doc/BRIEF.md
# DMA Transfer Request Controller

This block decides when one DMA channel may start moving data and how long it keeps the system bus once it has it. Software-side logic programs a transfer count and sets the channel enable. From then on the block watches its request source, asks an arbiter for the bus, and hands the transfer engine one start strobe per transfer unit. The engine answers each strobe with a one-cycle done pulse. The block also counts the units and blocks it has run.

There are two request sources. With the internal (auto) source, a request is always present while the channel is enabled. With the external source, requests come from an active-low pin. That pin is synchronized and then sensed either as a low level or as a falling edge. A falling edge that arrives while a transfer is still running is held and served later. An accepted external request can be answered with a one-cycle active-low acknowledge.

The bus is held in one of three ways. In cycle steal mode it is held for one unit. In burst mode it is held for the whole programmed count. In block mode it is held for one block of units. Which of these modes are legal depends on the request source. When the programmed count runs out, the enable clears itself.

Top module: `dma_req_ctrl`

## Requirements
- R1: After reset, `en_o`=0, `bus_req`=0, `bus_rel`=0, `xfer_go`=0, `ack_n`=1 and `remain_cnt`=0.
- R2: A one-cycle `en_set` with a nonzero `xfer_count` sets `en_o`=1 and loads `remain_cnt` with the count. An `en_set` with a count of 0 is ignored: `en_o` stays 0 and no bus request follows.
- R3: Auto source (`src_ext`=0) with cycle steal (`burst_mode`=0) and a count of N gives N `bus_req` strobes, N `xfer_go` strobes and N `bus_rel` strobes, one of each per unit. `bus_req` and `bus_rel` are never high together.
- R4: Auto source with burst (`burst_mode`=1) and a count of N gives one `bus_req`, N `xfer_go` strobes and one `bus_rel`.
- R5: With the auto source, `block_mode`=1 is ignored. Each count step is one unit, whatever `block_size` is.
- R6: External source with level sensing (`sense_edge`=0): no transfer starts while `req_n` is high, and transfers keep starting while `req_n` is held low.
- R7: External source with edge sensing (`sense_edge`=1): one falling edge of `req_n` starts exactly one request, however long `req_n` then stays low.
- R8: A falling edge that arrives while an earlier request is still being served is kept pending and served afterwards. Two edges therefore give two requests.
- R9: `ack_n` goes low for exactly one cycle per accepted external request, and only when `ack_en`=1. It never goes low with the auto source.
- R10: External source with `block_mode`=1: one request gives `block_size` `xfer_go` strobes inside a single bus tenure (one `bus_req`, one `bus_rel`), at most one acknowledge, and `remain_cnt` falls by one per block.
- R11: With the external source, `burst_mode`=1 is ignored and the bus is released after every unit.
- R12: When `remain_cnt` reaches 0, the block releases the bus, `en_o` drops to 0 and no further `bus_req` is issued. `remain_cnt` moves by at most one per cycle while enabled.
- R13: An `en_clr` during a burst lets the unit in flight finish, then releases the bus once. No further `xfer_go` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_set | input | 1 | One-cycle strobe: enable the channel and load the count |
| en_clr | input | 1 | One-cycle strobe: clear the channel enable |
| xfer_count | input | CNT_W | Count loaded on `en_set` (units, or blocks in block mode) |
| block_size | input | BLK_W | Units per block (0 is treated as 1) |
| src_ext | input | 1 | Request source: 1 = external pin, 0 = auto |
| burst_mode | input | 1 | Bus mode: 1 = burst, 0 = cycle steal |
| block_mode | input | 1 | 1 = block transfer (external source only) |
| sense_edge | input | 1 | 1 = falling-edge sensing, 0 = low-level sensing |
| ack_en | input | 1 | 1 = drive the acknowledge for accepted external requests |
| req_n | input | 1 | Asynchronous active-low external request |
| bus_gnt | input | 1 | Bus granted by the arbiter (level) |
| unit_done | input | 1 | One-cycle pulse from the engine: a unit has finished |
| bus_req | output | 1 | One-cycle strobe asking for the bus |
| bus_rel | output | 1 | One-cycle strobe giving the bus back |
| xfer_go | output | 1 | One-cycle strobe starting one transfer unit |
| ack_n | output | 1 | Active-low one-cycle request acknowledge |
| en_o | output | 1 | Current channel enable |
| remain_cnt | output | CNT_W | Remaining count |

## Verification
A wrong tenure state shows up at once as a mismatch between `bus_req`, `bus_rel` and `xfer_go` counts. It appears within one unit's latency: an extra release in burst mode, or a missing one in cycle steal mode. A lost pending edge or a stuck unit-in-block counter does not show at the moment it goes wrong. It appears only when the request finishes, as too few or too many `xfer_go` strobes and a `remain_cnt` that is off by one. A wrong enable shows as a request after the count has run out, or as no request at all after a valid enable.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_BUSY = 2'd2
    } req_state_e;

    typedef struct packed {
        logic src_ext;
        logic burst;
        logic block;
        logic sense_edge;
        logic ack_en;
    } dma_mode_t;

    // burst only legal with the auto source
    function automatic logic eff_burst(input dma_mode_t m);
        return m.burst & ~m.src_ext;
    endfunction

    // block only legal with the external source
    function automatic logic eff_block(input dma_mode_t m);
        return m.block & m.src_ext;
    endfunction

endpackage

// File: rtl/dma_req_sense.sv
module dma_req_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n,
    input  logic arm,
    input  logic sense_edge,
    input  logic accept,
    output logic ext_trig
);
    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   prev;
        logic                   pend;
    } sense_t;

    sense_t s_q, s_d;
    logic   fall;

    assign fall = s_q.prev & ~s_q.chain[LAST];

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = req_n;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
        s_d.prev = s_q.chain[LAST];
        if (!arm) begin
            s_d.pend = 1'b0;
        end else begin
            s_d.pend = (s_q.pend & ~accept) | fall;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{chain: '1, prev: 1'b1, pend: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign ext_trig = sense_edge ? s_q.pend : ~s_q.chain[LAST];

endmodule

// File: rtl/dma_req_core.sv
module dma_req_core
    import dma_req_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int BLK_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dma_mode_t        mode,
    input  logic             en_set,
    input  logic             en_clr,
    input  logic [CNT_W-1:0] xfer_count,
    input  logic [BLK_W-1:0] block_size,
    input  logic             ext_trig,
    input  logic             bus_gnt,
    input  logic             unit_done,
    output logic             accept,
    output logic             bus_req,
    output logic             bus_rel,
    output logic             xfer_go,
    output logic             ack_n,
    output logic             en_o,
    output logic [CNT_W-1:0] remain_cnt
);
    localparam logic [BLK_W-1:0] ONE_UNIT = BLK_W'(1);

    typedef struct packed {
        req_state_e       st;
        logic             en;
        logic [CNT_W-1:0] cnt;
        logic [BLK_W-1:0] blk_left;
        logic             req;
        logic             rel;
        logic             go;
        logic             ack_n;
    } core_t;

    core_t c_q, c_d;
    logic  trig;
    logic  [CNT_W-1:0] cnt_dec;

    assign trig    = mode.src_ext ? ext_trig : 1'b1;
    assign cnt_dec = c_q.cnt - CNT_W'(1);

    always_comb begin
        c_d       = c_q;
        c_d.req   = 1'b0;
        c_d.rel   = 1'b0;
        c_d.go    = 1'b0;
        c_d.ack_n = 1'b1;
        accept    = 1'b0;

        if (en_set && !c_q.en && (xfer_count != '0)) begin
            c_d.en  = 1'b1;
            c_d.cnt = xfer_count;
        end
        if (en_clr) begin
            c_d.en = 1'b0;
        end

        unique case (c_q.st)
            ST_IDLE: begin
                if (c_q.en && !en_clr && trig) begin
                    c_d.st  = ST_WAIT;
                    c_d.req = 1'b1;
                    accept  = mode.src_ext;
                end
            end
            ST_WAIT: begin
                if (bus_gnt) begin
                    c_d.st       = ST_BUSY;
                    c_d.go       = 1'b1;
                    c_d.blk_left = (eff_block(mode) && block_size != '0) ? block_size : ONE_UNIT;
                    c_d.ack_n    = ~(mode.src_ext & mode.ack_en);
                end
            end
            ST_BUSY: begin
                if (unit_done) begin
                    if (c_q.blk_left > ONE_UNIT) begin
                        c_d.blk_left = c_q.blk_left - ONE_UNIT;
                        c_d.go       = 1'b1;
                    end else begin
                        c_d.cnt = cnt_dec;
                        if (cnt_dec == '0) begin
                            c_d.en  = 1'b0;
                            c_d.rel = 1'b1;
                            c_d.st  = ST_IDLE;
                        end else if (eff_burst(mode) && c_q.en && !en_clr) begin
                            c_d.go       = 1'b1;
                            c_d.blk_left = ONE_UNIT;
                        end else begin
                            c_d.rel = 1'b1;
                            c_d.st  = ST_IDLE;
                        end
                    end
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, en: 1'b0, cnt: '0, blk_left: '0,
                     req: 1'b0, rel: 1'b0, go: 1'b0, ack_n: 1'b1};
        end else begin
            c_q <= c_d;
        end
    end

    assign bus_req    = c_q.req;
    assign bus_rel    = c_q.rel;
    assign xfer_go    = c_q.go;
    assign ack_n      = c_q.ack_n;
    assign en_o       = c_q.en;
    assign remain_cnt = c_q.cnt;

endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
    import dma_req_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int BLK_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_set,
    input  logic             en_clr,
    input  logic [CNT_W-1:0] xfer_count,
    input  logic [BLK_W-1:0] block_size,
    input  logic             src_ext,
    input  logic             burst_mode,
    input  logic             block_mode,
    input  logic             sense_edge,
    input  logic             ack_en,
    input  logic             req_n,
    input  logic             bus_gnt,
    input  logic             unit_done,
    output logic             bus_req,
    output logic             bus_rel,
    output logic             xfer_go,
    output logic             ack_n,
    output logic             en_o,
    output logic [CNT_W-1:0] remain_cnt
);
    dma_mode_t mode;
    logic      ext_trig;
    logic      accept;
    logic      arm;

    assign mode = '{src_ext: src_ext, burst: burst_mode, block: block_mode,
                    sense_edge: sense_edge, ack_en: ack_en};
    assign arm  = en_o & src_ext & sense_edge;

    dma_req_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_n      (req_n),
        .arm        (arm),
        .sense_edge (sense_edge),
        .accept     (accept),
        .ext_trig   (ext_trig)
    );

    dma_req_core #(.CNT_W(CNT_W), .BLK_W(BLK_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .en_set     (en_set),
        .en_clr     (en_clr),
        .xfer_count (xfer_count),
        .block_size (block_size),
        .ext_trig   (ext_trig),
        .bus_gnt    (bus_gnt),
        .unit_done  (unit_done),
        .accept     (accept),
        .bus_req    (bus_req),
        .bus_rel    (bus_rel),
        .xfer_go    (xfer_go),
        .ack_n      (ack_n),
        .en_o       (en_o),
        .remain_cnt (remain_cnt)
    );

endmodule

// File: rtl/dma_req_ctrl_chk.sv
module dma_req_ctrl_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_req,
    input logic             bus_rel,
    input logic             xfer_go,
    input logic             ack_n,
    input logic             en_o,
    input logic             src_ext,
    input logic             ack_en,
    input logic [CNT_W-1:0] remain_cnt
);
    AST_REQ_REL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && bus_rel)); // R3

    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> $past(en_o)); // R2

    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |=> ack_n); // R9

    AST_ACK_EXT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> (src_ext && ack_en && xfer_go)); // R9

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && $past(en_o)) |->
            (remain_cnt == $past(remain_cnt) || remain_cnt == $past(remain_cnt) - 1'b1)); // R12

    AST_GO_NOT_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_go && bus_req)); // R4

endmodule

bind dma_req_ctrl dma_req_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_rel    (bus_rel),
    .xfer_go    (xfer_go),
    .ack_n      (ack_n),
    .en_o       (en_o),
    .src_ext    (src_ext),
    .ack_en     (ack_en),
    .remain_cnt (remain_cnt)
);

// File: tb/dma_req_ctrl_bench.sv
`timescale 1ns/1ps
module dma_req_ctrl_bench;
    localparam int CW = 16;
    localparam int BW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_set = 1'b0, en_clr = 1'b0;
    logic [CW-1:0] xfer_count = '0;
    logic [BW-1:0] block_size = '0;
    logic src_ext = 1'b0, burst_mode = 1'b0, block_mode = 1'b0;
    logic sense_edge = 1'b0, ack_en = 1'b0, req_n = 1'b1;
    logic bus_gnt, unit_done, d1;
    logic bus_req, bus_rel, xfer_go, ack_n, en_o;
    logic [CW-1:0] remain_cnt;

    int checks = 0, errors = 0;
    int n_req = 0, n_rel = 0, n_go = 0, n_ack = 0;
    int b_req, b_rel, b_go, b_ack;
    bit done_flag = 0;

    always #4 clk = ~clk; // 125 MHz

    dma_req_ctrl #(.CNT_W(CW), .BLK_W(BW)) u_dma_req_ctrl (
        .clk(clk), .rst_n(rst_n), .en_set(en_set), .en_clr(en_clr),
        .xfer_count(xfer_count), .block_size(block_size), .src_ext(src_ext),
        .burst_mode(burst_mode), .block_mode(block_mode), .sense_edge(sense_edge),
        .ack_en(ack_en), .req_n(req_n), .bus_gnt(bus_gnt), .unit_done(unit_done),
        .bus_req(bus_req), .bus_rel(bus_rel), .xfer_go(xfer_go), .ack_n(ack_n),
        .en_o(en_o), .remain_cnt(remain_cnt)
    );

    // arbiter and engine models
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_gnt <= 1'b0; d1 <= 1'b0; unit_done <= 1'b0;
        end else begin
            if (bus_req) bus_gnt <= 1'b1;
            else if (bus_rel) bus_gnt <= 1'b0;
            d1 <= xfer_go;
            unit_done <= d1;
        end
    end

    always @(posedge clk) begin
        if (rst_n) begin
            n_req += int'(bus_req);
            n_rel += int'(bus_rel);
            n_go  += int'(xfer_go);
            n_ack += int'(!ack_n);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic mark();
        b_req = n_req; b_rel = n_rel; b_go = n_go; b_ack = n_ack;
    endtask

    task automatic enable(input int cnt);
        xfer_count = CW'(cnt);
        en_set = 1'b1; cyc(1); en_set = 1'b0;
    endtask

    task automatic wait_off();
        int k = 0;
        while (en_o && k < 3000) begin cyc(1); k++; end
        cyc(8);
    endtask

    task automatic t_reset();
        check(en_o == 0 && bus_req == 0 && bus_rel == 0 && xfer_go == 0,
              "R1 outputs idle", int'(en_o), 0);
        check(ack_n == 1 && remain_cnt == 0, "R1 ack/count", int'(remain_cnt), 0);
    endtask

    task automatic t_zero_count();
        src_ext = 0; burst_mode = 0; block_mode = 0;
        mark();
        enable(0); cyc(20);
        check(en_o == 0, "R2 zero count ignored en", int'(en_o), 0);
        check(n_req - b_req == 0, "R2 zero count no req", n_req - b_req, 0);
    endtask

    task automatic t_auto_steal();
        src_ext = 0; burst_mode = 0; block_mode = 0;
        mark(); enable(4);
        wait_off();
        check(n_req - b_req == 4, "R3 steal req", n_req - b_req, 4);
        check(n_rel - b_rel == 4, "R3 steal rel", n_rel - b_rel, 4);
        check(n_go - b_go == 4, "R3 steal go", n_go - b_go, 4);
        check(n_ack - b_ack == 0, "R9 no ack in auto", n_ack - b_ack, 0);
        check(en_o == 0 && remain_cnt == 0, "R12 exhausted", int'(remain_cnt), 0);
    endtask

    task automatic t_auto_burst();
        src_ext = 0; burst_mode = 1; block_mode = 0;
        mark(); enable(5);
        wait_off();
        check(n_req - b_req == 1, "R4 burst req", n_req - b_req, 1);
        check(n_go - b_go == 5, "R4 burst go", n_go - b_go, 5);
        check(n_rel - b_rel == 1, "R4 burst rel", n_rel - b_rel, 1);
        mark(); cyc(30);
        check(n_req - b_req == 0, "R12 no req after exhaust", n_req - b_req, 0);
    endtask

    task automatic t_auto_block_ignored();
        src_ext = 0; burst_mode = 0; block_mode = 1; block_size = 3;
        mark(); enable(2);
        wait_off();
        check(n_go - b_go == 2, "R5 block ignored go", n_go - b_go, 2);
        check(n_req - b_req == 2, "R5 block ignored req", n_req - b_req, 2);
        block_mode = 0;
    endtask

    task automatic t_ext_level();
        src_ext = 1; sense_edge = 0; ack_en = 1; burst_mode = 1; block_mode = 0;
        req_n = 1;
        mark(); enable(3); cyc(20);
        check(en_o == 1 && remain_cnt == 3, "R2 loaded count", int'(remain_cnt), 3);
        check(n_go - b_go == 0, "R6 no xfer while high", n_go - b_go, 0);
        req_n = 0;
        wait_off();
        req_n = 1;
        check(n_go - b_go == 3, "R6 level go", n_go - b_go, 3);
        check(n_req - b_req == 3 && n_rel - b_rel == 3, "R11 ext burst ignored", n_req - b_req, 3);
        check(n_ack - b_ack == 3, "R9 ack per request", n_ack - b_ack, 3);
        burst_mode = 0; cyc(5);
    endtask

    task automatic t_ext_edge();
        src_ext = 1; sense_edge = 1; ack_en = 0; block_mode = 0; req_n = 1;
        cyc(5);
        mark(); enable(5); cyc(5);
        req_n = 0; cyc(40); req_n = 1; cyc(10);
        check(n_go - b_go == 1, "R7 one edge one unit", n_go - b_go, 1);
        check(n_ack - b_ack == 0, "R9 ack disabled", n_ack - b_ack, 0);
        check(remain_cnt == 4, "R7 count step", int'(remain_cnt), 4);
        mark();
        req_n = 0; cyc(2); req_n = 1; cyc(2); req_n = 0; cyc(2); req_n = 1;
        cyc(40);
        check(n_go - b_go == 2, "R8 pending edge kept", n_go - b_go, 2);
        check(remain_cnt == 2, "R8 count", int'(remain_cnt), 2);
        en_clr = 1; cyc(1); en_clr = 0; cyc(5);
    endtask

    task automatic t_block();
        src_ext = 1; sense_edge = 1; ack_en = 1; block_mode = 1; block_size = 4;
        req_n = 1; cyc(5);
        mark(); enable(2); cyc(5);
        req_n = 0; cyc(3); req_n = 1; cyc(40);
        check(n_go - b_go == 4, "R10 block units", n_go - b_go, 4);
        check(n_req - b_req == 1 && n_rel - b_rel == 1, "R10 one tenure", n_rel - b_rel, 1);
        check(n_ack - b_ack == 1, "R10 one ack", n_ack - b_ack, 1);
        check(remain_cnt == 1, "R10 count per block", int'(remain_cnt), 1);
        en_clr = 1; cyc(1); en_clr = 0; cyc(5);
        block_mode = 0;
    endtask

    task automatic t_clr_burst();
        int k = 0;
        int g;
        src_ext = 0; burst_mode = 1; block_mode = 0;
        mark(); enable(50);
        while (n_go - b_go < 3 && k < 500) begin cyc(1); k++; end
        g = n_go - b_go;
        en_clr = 1; cyc(1); en_clr = 0;
        cyc(20);
        check(en_o == 0, "R13 enable cleared", int'(en_o), 0);
        check(n_rel - b_rel == 1, "R13 one release", n_rel - b_rel, 1);
        check(n_go - b_go <= g + 1, "R13 go stops", n_go - b_go, g + 1);
        g = n_go; cyc(20);
        check(n_go == g, "R13 no further go", n_go, g);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        finish_run();
    end

    initial begin
        cyc(3); rst_n = 1'b1; cyc(2);
        t_reset();
        t_zero_count();
        t_auto_steal();
        t_auto_burst();
        t_auto_block_ignored();
        t_ext_level();
        t_ext_edge();
        t_block();
        t_clr_burst();
        finish_run();
    end

endmodule